// File: doc/BRIEF.md
# Floating-Point Context Status Tracker

This block keeps the two-bit floating-point context status field of a machine status register. The field records whether floating-point state is switched off, freshly initialised, clean (saved), or modified since it was last saved. Privileged software writes the field directly. The execution pipeline sends already-classified strobes, and the block uses them to mark the context modified.

A static policy input selects how the block marks the context modified. The write-one policy dirties the field only on real changes to floating-point state. The write-any policy also dirties it on every compare or float-to-integer conversion. The always-dirty policy shows the field as only off or modified.

The block also drives two signals to the issue stage:
- an enable that lets floating-point and vector floating-point instructions run;
- a same-cycle illegal-instruction flag for any such instruction attempted while the context is off.

Top module: `fpctx_tracker`

## Requirements
- R1: After reset the field reads as the configured reset value, which is 0 by default. The encodings are 0 = Off, 1 = Initial, 2 = Clean and 3 = Dirty. With the default value, `sd_o` and `fp_en_o` are 0.
- R2: Under the write-one policy (`policy_i` = 0), a privileged write stores `csr_wdata_i` unchanged. The value appears on `status_o` after the next clock edge.
- R3: Under the always-dirty policy (`policy_i` = 2), `status_o` only ever reads 0 or 3. A privileged write of 1 or 2 reads back as 3.
- R4: While the field is not Off, a pulse on `fcsr_wr_i` or `fpr_wr_i` makes the field 3 after the next edge. This holds under every policy.
- R5: Under the write-one policy, a compare or conversion strobe (`cmpcvt_i`) with `cmpcvt_exc_i` = 0 leaves the field unchanged. With `cmpcvt_exc_i` = 1 it makes the field 3.
- R6: Under the write-any policy (`policy_i` = 1), a compare or conversion strobe makes the field 3 whether or not it raised an exception.
- R7: `sd_o` is 1 exactly when `status_o` is 3.
- R8: `fp_en_o` is 1 exactly when `status_o` is not 0. `illegal_o` is `fp_issue_i` AND (`status_o` = 0) in the same cycle.
- R9: While the field is Off, event strobes leave it at 0, and an issued instruction does not change it.
- R10: When a privileged write and a dirtying event occur in the same cycle, the field becomes 3.
- R11: The reserved policy code 3 behaves like the write-one policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy_i | input | 2 | Dirty-marking policy: 0 write-one, 1 write-any, 2 always-dirty, 3 reserved (acts as write-one) |
| csr_wr_i | input | 1 | Privileged write of the field |
| csr_wdata_i | input | 2 | Value of the privileged write |
| fcsr_wr_i | input | 1 | Explicit write to a floating-point flags, rounding-mode or control register |
| fpr_wr_i | input | 1 | Retired instruction wrote a floating-point register |
| cmpcvt_i | input | 1 | Retired floating-point compare or float-to-integer conversion |
| cmpcvt_exc_i | input | 1 | That compare or conversion raised an exception flag |
| fp_issue_i | input | 1 | A floating-point or vector floating-point instruction is being issued |
| status_o | output | 2 | Current field value |
| sd_o | output | 1 | Summary dirty bit |
| fp_en_o | output | 1 | Floating-point execution enabled |
| illegal_o | output | 1 | Illegal-instruction indication for the issued instruction |

## Verification
The bench goes after five corner cases:
- **Same-cycle conflict.** A privileged write of 0 in the same cycle as a register-write strobe must give Dirty. A design that let the write win would switch the context off.
- **Strobes while Off.** These must leave the field at 0. A design that did not gate them would silently switch floating point on.
- **Compare without an exception.** Under write-one it must not dirty the field, while under write-any it must. Swapping the two cases shows up as a wrong final value.
- **Always-dirty writes.** Writes of 1 and 2 must read back as 3; storing them unchanged is caught directly.
- **Reserved policy code.** It must act like write-one. A design that decoded it as write-any would dirty the field on an exception-free compare.

// File: rtl/fpctx_pkg.sv
package fpctx_pkg;

    localparam int unsigned FS_W  = 2;
    localparam int unsigned POL_W = 2;

    typedef enum logic [FS_W-1:0] {
        FS_OFF   = 2'd0,
        FS_INIT  = 2'd1,
        FS_CLEAN = 2'd2,
        FS_DIRTY = 2'd3
    } fs_e;

    typedef enum logic [POL_W-1:0] {
        POL_WRITE_ONE    = 2'd0,
        POL_WRITE_ANY    = 2'd1,
        POL_ALWAYS_DIRTY = 2'd2,
        POL_RESERVED     = 2'd3
    } pol_e;

    typedef struct packed {
        fs_e fs;
    } fpctx_state_t;

endpackage

// File: rtl/fpctx_dirty_detect.sv
module fpctx_dirty_detect
    import fpctx_pkg::*;
(
    input  logic             [POL_W-1:0] policy_i,
    input  logic                         live_i,
    input  logic                         fcsr_wr_i,
    input  logic                         fpr_wr_i,
    input  logic                         cmpcvt_i,
    input  logic                         cmpcvt_exc_i,
    output logic                         dirty_o
);
    logic cmp_counts;

    always_comb begin
        // Only write-any dirties on exception-free compares; others need a raised flag.
        if (pol_e'(policy_i) == POL_WRITE_ANY) begin
            cmp_counts = cmpcvt_i;
        end else begin
            cmp_counts = cmpcvt_i & cmpcvt_exc_i;
        end
        // Strobes from an Off context belong to trapped instructions.
        dirty_o = live_i & (fcsr_wr_i | fpr_wr_i | cmp_counts);
    end
endmodule

// File: rtl/fpctx_wnorm.sv
module fpctx_wnorm
    import fpctx_pkg::*;
(
    input  logic            collapse_i,
    input  logic [FS_W-1:0] raw_i,
    output logic [FS_W-1:0] norm_o
);
    always_comb begin
        if (collapse_i && (raw_i != FS_W'(FS_OFF))) begin
            norm_o = FS_W'(FS_DIRTY);
        end else begin
            norm_o = raw_i;
        end
    end
endmodule

// File: rtl/fpctx_tracker.sv
module fpctx_tracker
    import fpctx_pkg::*;
#(
    parameter int unsigned RESET_FS = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       policy_i,
    input  logic             csr_wr_i,
    input  logic [1:0]       csr_wdata_i,
    input  logic             fcsr_wr_i,
    input  logic             fpr_wr_i,
    input  logic             cmpcvt_i,
    input  logic             cmpcvt_exc_i,
    input  logic             fp_issue_i,
    output logic [1:0]       status_o,
    output logic             sd_o,
    output logic             fp_en_o,
    output logic             illegal_o
);
    localparam fs_e RST_FS = fs_e'(RESET_FS[FS_W-1:0]);

    fpctx_state_t state_d, state_q;

    logic            collapse;
    logic [FS_W-1:0] view_fs;
    logic [FS_W-1:0] wr_norm;
    logic            live;
    logic            dirty;

    assign collapse = (pol_e'(policy_i) == POL_ALWAYS_DIRTY);

    // Read view: a stored nonzero reset value is shown collapsed under always-dirty.
    fpctx_wnorm u_view (
        .collapse_i (collapse),
        .raw_i      (state_q.fs),
        .norm_o     (view_fs)
    );

    fpctx_wnorm u_wr (
        .collapse_i (collapse),
        .raw_i      (csr_wdata_i),
        .norm_o     (wr_norm)
    );

    assign live = (view_fs != FS_W'(FS_OFF));

    fpctx_dirty_detect u_dirty (
        .policy_i     (policy_i),
        .live_i       (live),
        .fcsr_wr_i    (fcsr_wr_i),
        .fpr_wr_i     (fpr_wr_i),
        .cmpcvt_i     (cmpcvt_i),
        .cmpcvt_exc_i (cmpcvt_exc_i),
        .dirty_o      (dirty)
    );

    always_comb begin
        state_d = state_q;
        if (dirty) begin
            state_d.fs = FS_DIRTY;
        end else if (csr_wr_i) begin
            state_d.fs = fs_e'(wr_norm);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.fs <= RST_FS;
        end else begin
            state_q <= state_d;
        end
    end

    assign status_o  = view_fs;
    assign sd_o      = (view_fs == FS_W'(FS_DIRTY));
    assign fp_en_o   = live;
    assign illegal_o = fp_issue_i & ~live;
endmodule

// File: rtl/fpctx_tracker_chk.sv
module fpctx_tracker_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] policy_i,
    input logic       csr_wr_i,
    input logic       fcsr_wr_i,
    input logic       fpr_wr_i,
    input logic       cmpcvt_i,
    input logic       cmpcvt_exc_i,
    input logic       fp_issue_i,
    input logic [1:0] status_o,
    input logic       sd_o,
    input logic       fp_en_o,
    input logic       illegal_o
);
    assert_reg_dirty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o != 2'd0 && (fcsr_wr_i || fpr_wr_i)) |=> (status_o == 2'd3));

    assert_collapsed_view_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (policy_i == 2'd2) |-> (status_o == 2'd0 || status_o == 2'd3));

    assert_sd_track_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sd_o == (status_o == 2'd3));

    assert_illegal_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_issue_i && status_o == 2'd0) |-> (illegal_o && !fp_en_o));

    assert_off_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == 2'd0 && !csr_wr_i) |=> (status_o == 2'd0));

    assert_quiet_compare_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (policy_i == 2'd0 && !csr_wr_i && !fcsr_wr_i && !fpr_wr_i
         && cmpcvt_i && !cmpcvt_exc_i) |=> $stable(status_o));

    assert_any_compare_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (policy_i == 2'd1 && status_o != 2'd0 && cmpcvt_i) |=> (status_o == 2'd3));
endmodule

bind fpctx_tracker fpctx_tracker_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .policy_i     (policy_i),
    .csr_wr_i     (csr_wr_i),
    .fcsr_wr_i    (fcsr_wr_i),
    .fpr_wr_i     (fpr_wr_i),
    .cmpcvt_i     (cmpcvt_i),
    .cmpcvt_exc_i (cmpcvt_exc_i),
    .fp_issue_i   (fp_issue_i),
    .status_o     (status_o),
    .sd_o         (sd_o),
    .fp_en_o      (fp_en_o),
    .illegal_o    (illegal_o)
);

// File: tb/fpctx_tracker_test.sv
module fpctx_tracker_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] policy_i = 2'd0;
    logic       csr_wr_i = 1'b0;
    logic [1:0] csr_wdata_i = 2'd0;
    logic       fcsr_wr_i = 1'b0;
    logic       fpr_wr_i = 1'b0;
    logic       cmpcvt_i = 1'b0;
    logic       cmpcvt_exc_i = 1'b0;
    logic       fp_issue_i = 1'b0;
    logic [1:0] status_o;
    logic       sd_o, fp_en_o, illegal_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    fpctx_tracker uut (
        .clk(clk), .rst_n(rst_n), .policy_i(policy_i),
        .csr_wr_i(csr_wr_i), .csr_wdata_i(csr_wdata_i),
        .fcsr_wr_i(fcsr_wr_i), .fpr_wr_i(fpr_wr_i),
        .cmpcvt_i(cmpcvt_i), .cmpcvt_exc_i(cmpcvt_exc_i),
        .fp_issue_i(fp_issue_i), .status_o(status_o),
        .sd_o(sd_o), .fp_en_o(fp_en_o), .illegal_o(illegal_o)
    );

    // Row: {csr_wr, wdata[1:0], fcsr, fpr, cmp, exc, issue, exp_illegal, exp_status[1:0]}
    localparam int NV = 12;
    localparam logic [10:0] VECS [NV] = '{
        11'b0_00_0_1_0_0_1_1_00,  // R9 R8: register write and issue while Off
        11'b1_01_0_0_0_0_0_0_01,  // R2: write Initial
        11'b0_00_0_0_1_0_0_0_01,  // R5: quiet compare leaves it
        11'b0_00_0_0_1_1_0_0_11,  // R5: compare with exception dirties
        11'b1_10_0_0_0_0_0_0_10,  // R2: write Clean
        11'b0_00_1_0_0_0_0_0_11,  // R4: control register write dirties
        11'b1_01_0_0_0_0_0_0_01,  // R2: write Initial
        11'b1_00_0_1_0_0_0_0_11,  // R10: event beats write of Off
        11'b1_00_0_0_0_0_0_0_00,  // R2: write Off
        11'b0_00_1_0_0_0_0_0_00,  // R9: strobe while Off ignored
        11'b0_00_0_0_0_0_1_1_00,  // R8: issue while Off
        11'b1_11_0_0_0_0_1_1_11   // R2 R8: write Dirty while issue flagged
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle();
        csr_wr_i = 0; csr_wdata_i = 0; fcsr_wr_i = 0; fpr_wr_i = 0;
        cmpcvt_i = 0; cmpcvt_exc_i = 0; fp_issue_i = 0;
    endtask

    // Drives at a falling edge, the rising edge registers, checks at the next falling edge.
    task automatic step(input string req, input logic c, input logic [1:0] w,
                        input logic f, input logic p, input logic m, input logic e,
                        input logic [1:0] exp_st);
        csr_wr_i = c; csr_wdata_i = w; fcsr_wr_i = f; fpr_wr_i = p;
        cmpcvt_i = m; cmpcvt_exc_i = e; fp_issue_i = 0;
        @(negedge clk);
        idle();
        chk(req, int'(status_o), int'(exp_st));
        chk({req, " R7"}, int'(sd_o), int'(exp_st == 2'd3));
    endtask

    task automatic do_reset(input logic [1:0] pol);
        idle();
        rst_n = 0;
        policy_i = pol;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset(2'd0);
        // R1: reset state
        chk("R1 status", int'(status_o), 0);
        chk("R1 sd", int'(sd_o), 0);
        chk("R1 fp_en", int'(fp_en_o), 0);

        for (int i = 0; i < NV; i++) begin
            logic [10:0] v;
            v = VECS[i];
            csr_wr_i = v[10]; csr_wdata_i = v[9:8]; fcsr_wr_i = v[7]; fpr_wr_i = v[6];
            cmpcvt_i = v[5]; cmpcvt_exc_i = v[4]; fp_issue_i = v[3];
            #1;
            chk($sformatf("R8 illegal row %0d", i), int'(illegal_o), int'(v[2]));
            @(negedge clk);
            idle();
            chk($sformatf("R2/R4/R5/R9/R10 status row %0d", i), int'(status_o), int'(v[1:0]));
            chk($sformatf("R7 sd row %0d", i), int'(sd_o), int'(v[1:0] == 2'd3));
            chk($sformatf("R8 fp_en row %0d", i), int'(fp_en_o), int'(v[1:0] != 2'd0));
        end

        // R3: always-dirty collapses Initial and Clean
        do_reset(2'd2);
        step("R3 write 1", 1, 2'd1, 0, 0, 0, 0, 2'd3);
        step("R3 write 0", 1, 2'd0, 0, 0, 0, 0, 2'd0);
        step("R3 write 2", 1, 2'd2, 0, 0, 0, 0, 2'd3);

        // R6: write-any dirties on a quiet compare
        do_reset(2'd1);
        step("R6 setup", 1, 2'd2, 0, 0, 0, 0, 2'd2);
        step("R6 quiet compare", 0, 2'd0, 0, 0, 1, 0, 2'd3);

        // R11: reserved code acts as write-one
        do_reset(2'd3);
        step("R11 setup", 1, 2'd1, 0, 0, 0, 0, 2'd1);
        step("R11 quiet compare", 0, 2'd0, 0, 0, 1, 0, 2'd1);
        step("R11 flagged compare", 0, 2'd0, 0, 0, 1, 1, 2'd3);

        // R4: register write under always-dirty
        do_reset(2'd2);
        step("R4 setup", 1, 2'd3, 0, 0, 0, 0, 2'd3);
        step("R4 fpr", 0, 2'd0, 0, 1, 0, 0, 2'd3);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule